// File: doc/BRIEF.md
# RTC Tick Prescaler with Control

This block is the front end of a real-time clock. It counts a 32.768 kHz tick and, once every 32,768 ticks, emits a one-cycle increment pulse for a downstream seconds counter. Software sees the live tick count through a read-only register. It starts, stops and zeroes the counter through a control register. A selectable power-of-two sub-second rate raises its own interrupt flag. An alarm-match input from outside sets a third flag. Software clears each flag by writing a one to it, and one level interrupt output reports that any flag is set.

The tick can come from two places, chosen by `modeSync`. It can be a free-running clock (`tickClk`) that is asynchronous to the bus clock. In that case the counter runs in the tick domain, is kept in Gray code and crosses into the bus domain through a flop synchronizer, so every read sees a coherent value. It can also be a strobe (`tickStb`) that is synchronous to the bus clock. In that case a bus-domain counter is read directly.

The register map uses a 2-bit word address. Address 0 holds the flags, address 1 the tick count, address 2 the control bits and address 3 the sub-second select.

Top module: `rtc_tick_prescaler`

## Requirements
- R1: With `modeSync`=1, enable set and counter reset clear, the tick count advances by one on every bus clock cycle in which `tickStb` is high. Address 1 returns the count in bits 15:1 and returns bit 0 as 0.
- R2: The count wraps from 32767 to 0. On that step `secPulse` goes high for exactly one cycle and flag bit 0 is set.
- R3: When the enable bit (address 2, bit 0) is 0, the count holds its value whatever the tick input does.
- R4: While the counter-reset bit (address 2, bit 1) is 1, the count reads 0 and stays 0 even if ticks arrive. After the bit is written back to 0, counting resumes from 0.
- R5: A high `alarmIn` sets flag bit 1.
- R6: Writing 1 to a flag bit at address 0 clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R7: The sub-second select sits at address 3, bits 2:0. For a value n from 0 to 6, flag bit 2 is set each time the count steps onto a multiple of 2^(n+8). A value of 7 raises no sub-second flag.
- R8: When a flag's set event and a write-one clear of that flag arrive in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when at least one of the three flags is set.
- R10: With `modeSync`=0 the count advances on rising edges of `tickClk`. When the tick clock is slower than the bus clock, two reads taken one bus cycle apart differ by at most one.
- R11: After reset the flags read 0, the control bits read 0, the sub-second select reads 7 and the count reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| tickClk | input | 1 | Free-running tick clock, asynchronous to the bus clock |
| tickStb | input | 1 | Tick strobe synchronous to the bus clock |
| modeSync | input | 1 | 1 selects `tickStb`, 0 selects `tickClk` |
| alarmIn | input | 1 | Alarm-match event, sets flag bit 1 |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Word address of the register |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for `busAddr` (combinational) |
| irq | output | 1 | Level interrupt, high when any flag is set |
| secPulse | output | 1 | One-cycle pulse on each 32,768-tick wrap |

## Verification
The condition that is hardest to reach from the ports is the once-per-second wrap. It needs 32,768 ticks, which the asynchronous clock would take far too long to deliver. The bench therefore selects the synchronous strobe, holds it high for 32,767 cycles, confirms that no wrap has been reported yet, and then gives one more strobe. To test read coherence, the bench switches to the asynchronous tick clock, which runs at 2.5 times the bus period. It then reads the count on every bus cycle and checks each step between consecutive reads. It also reaches the case where a flag's set event and its write-one clear land in the same cycle, by raising `alarmIn` in the same cycle as the write.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

  // Strobes from the control section into the counting datapath
  typedef struct packed {
    logic run;       // counters may advance
    logic clr;       // hold counters at zero
    logic syncMode;  // 1: bus-synchronous strobe source
  } dpCtl_t;

  // Events reported back by the datapath, one bus cycle wide
  typedef struct packed {
    logic sec;       // full-count wrap
    logic sub;       // sub-second tap reached
  } dpEvt_t;

endpackage

// File: rtl/rtc_tick_dp.sv
module rtc_tick_dp
  import rtc_tick_pkg::*;
#(
  parameter int CNT_W       = 15,
  parameter int SEL_W       = 3,
  parameter int SUB_BASE    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickClk,
  input  logic             tickStb,
  input  dpCtl_t           ctl,
  input  logic [SEL_W-1:0] subSel,
  output logic [CNT_W-1:0] cntView,
  output dpEvt_t           evt
);

  localparam logic [SEL_W-1:0] SEL_OFF = '1;

  function automatic logic [CNT_W-1:0] grayOf(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CNT_W-1:0] binOf(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic lowBitsZero(input logic [CNT_W-1:0] c,
                                       input logic [SEL_W-1:0] s);
    logic z;
    z = 1'b1;
    for (int i = 0; i < CNT_W; i++)
      if (i < SUB_BASE + int'(s) && c[i]) z = 1'b0;
    return z;
  endfunction

  // ---------------- tick clock domain ----------------
  logic [SYNC_STAGES-1:0] runSyncT, clrSyncT;
  logic                   runT, clrT;
  logic [CNT_W-1:0]       binT, binNextT, grayT;

  always_ff @(posedge tickClk or negedge rstN) begin
    if (!rstN) begin
      runSyncT <= '0;
      clrSyncT <= '0;
    end else begin
      runSyncT <= {runSyncT[SYNC_STAGES-2:0], ctl.run};
      clrSyncT <= {clrSyncT[SYNC_STAGES-2:0], ctl.clr};
    end
  end

  assign runT = runSyncT[SYNC_STAGES-1];
  assign clrT = clrSyncT[SYNC_STAGES-1];

  always_comb begin
    if (clrT)      binNextT = '0;
    else if (runT) binNextT = binT + 1'b1;
    else           binNextT = binT;
  end

  always_ff @(posedge tickClk or negedge rstN) begin
    if (!rstN) begin
      binT  <= '0;
      grayT <= '0;
    end else begin
      binT  <= binNextT;
      grayT <= grayOf(binNextT);
    end
  end

  // ---------------- bus clock domain ----------------
  logic [CNT_W-1:0] graySync [SYNC_STAGES];
  logic [CNT_W-1:0] asyncCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) graySync[i] <= '0;
    end else begin
      graySync[0] <= grayT;
      for (int i = 1; i < SYNC_STAGES; i++) graySync[i] <= graySync[i-1];
    end
  end

  assign asyncCnt = binOf(graySync[SYNC_STAGES-1]);

  logic [CNT_W-1:0] syncCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   syncCnt <= '0;
    else if (ctl.clr)            syncCnt <= '0;
    else if (ctl.run && tickStb) syncCnt <= syncCnt + 1'b1;
  end

  assign cntView = ctl.syncMode ? syncCnt : asyncCnt;

  // ---------------- event detection ----------------
  logic [CNT_W-1:0] prevCnt;
  logic             prevMode;
  logic             stepped, armed, secNow, subNow;
  dpEvt_t           evtQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCnt  <= '0;
      prevMode <= 1'b0;
      evtQ     <= '0;
    end else begin
      prevCnt  <= cntView;
      prevMode <= ctl.syncMode;
      evtQ.sec <= secNow;
      evtQ.sub <= subNow;
    end
  end

  assign stepped = (cntView == CNT_W'(prevCnt + 1'b1));
  assign armed   = ctl.run && !ctl.clr && (ctl.syncMode == prevMode);
  assign secNow  = armed && stepped && (cntView == '0);
  assign subNow  = armed && stepped && (subSel != SEL_OFF) &&
                   lowBitsZero(cntView, subSel);
  assign evt     = evtQ;

  // ---------------- assertions ----------------
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.clr) |-> syncCnt == '0);                               // R4
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(ctl.run) && !$past(ctl.clr)) |-> $stable(syncCnt));      // R3
  AST_SEC_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    evtQ.sec |-> $past(cntView) == '0);                              // R2
  AST_SUB_OFF: assert property (@(posedge clk) disable iff (!rstN)
    evtQ.sub |-> $past(subSel) != SEL_OFF);                          // R7

endmodule

// File: rtl/rtc_tick_ctl.sv
module rtc_tick_ctl
  import rtc_tick_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 2,
  localparam int DATA_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSync,
  input  logic              alarmIn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  cntView,
  input  dpEvt_t            evt,
  output dpCtl_t            ctl,
  output logic [SEL_W-1:0]  subSel,
  output logic              irq,
  output logic              secPulse
);

  localparam logic [ADDR_W-1:0] ADR_FLAG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_CNT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_CTL  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADR_SEL  = ADDR_W'(3);
  localparam int               FLG_N    = 3;

  logic             enQ, clrQ;
  logic [SEL_W-1:0] selQ;
  logic [FLG_N-1:0] flagQ, setVec, clrMask;
  logic             unusedWdata;

  assign unusedWdata = ^busWdata;

  // flag order: 0 wrap, 1 alarm, 2 sub-second
  assign setVec  = {evt.sub, alarmIn, evt.sec};
  assign clrMask = (busWr && busAddr == ADR_FLAG) ? busWdata[FLG_N-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      clrQ  <= 1'b0;
      selQ  <= '1;
      flagQ <= '0;
    end else begin
      flagQ <= (flagQ & ~clrMask) | setVec;
      if (busWr && busAddr == ADR_CTL) begin
        enQ  <= busWdata[0];
        clrQ <= busWdata[1];
      end
      if (busWr && busAddr == ADR_SEL) selQ <= busWdata[SEL_W-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADR_FLAG: busRdata[FLG_N-1:0] = flagQ;
      ADR_CNT:  busRdata = {cntView, 1'b0};
      ADR_CTL:  busRdata[1:0] = {clrQ, enQ};
      ADR_SEL:  busRdata[SEL_W-1:0] = selQ;
      default:  busRdata = '0;
    endcase
  end

  assign ctl.run      = enQ;
  assign ctl.clr      = clrQ;
  assign ctl.syncMode = modeSync;
  assign subSel       = selQ;
  assign irq          = |flagQ;
  assign secPulse     = evt.sec;

  AST_W1C_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (($past(flagQ) & ~flagQ & ~$past(clrMask)) == '0));             // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (($past(setVec) & ~flagQ) == '0));                               // R8

endmodule

// File: rtl/rtc_tick_prescaler.sv
module rtc_tick_prescaler
  import rtc_tick_pkg::*;
#(
  parameter int CNT_W       = 15,
  parameter int SEL_W       = 3,
  parameter int SUB_BASE    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickClk,
  input  logic              tickStb,
  input  logic              modeSync,
  input  logic              alarmIn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W:0]    busWdata,
  output logic [CNT_W:0]    busRdata,
  output logic              irq,
  output logic              secPulse
);

  dpCtl_t           ctlS;
  dpEvt_t           evtS;
  logic [CNT_W-1:0] cntView;
  logic [SEL_W-1:0] subSel;

  rtc_tick_ctl #(
    .CNT_W (CNT_W),
    .SEL_W (SEL_W),
    .ADDR_W(ADDR_W)
  ) ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .modeSync(modeSync),
    .alarmIn (alarmIn),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .cntView (cntView),
    .evt     (evtS),
    .ctl     (ctlS),
    .subSel  (subSel),
    .irq     (irq),
    .secPulse(secPulse)
  );

  rtc_tick_dp #(
    .CNT_W      (CNT_W),
    .SEL_W      (SEL_W),
    .SUB_BASE   (SUB_BASE),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .tickClk(tickClk),
    .tickStb(tickStb),
    .ctl    (ctlS),
    .subSel (subSel),
    .cntView(cntView),
    .evt    (evtS)
  );

endmodule

// File: tb/rtc_tick_prescaler_tb_top.sv
module rtc_tick_prescaler_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0, tickClk = 1'b0, rstN = 1'b0;
  logic        tickStb = 1'b0, modeSync = 1'b1, alarmIn = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [15:0] busWdata = '0, busRdata;
  logic        irq, secPulse;

  int nCmp = 0, nBad = 0, secSeen = 0;
  bit done = 0;

  logic [15:0] actQ[$], expQ[$];
  string       tagQ[$];
  event        obsEv;

  always #2 clk = ~clk;       // 250 MHz bus clock
  always #5 tickClk = ~tickClk;

  rtc_tick_prescaler dut_i (
    .clk(clk), .rstN(rstN), .tickClk(tickClk), .tickStb(tickStb),
    .modeSync(modeSync), .alarmIn(alarmIn), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irq(irq), .secPulse(secPulse)
  );

  always @(posedge clk) if (rstN && secPulse) secSeen++;

  task automatic drain();
    while (actQ.size() > 0) begin
      logic [15:0] a, e;
      string t;
      a = actQ.pop_front(); e = expQ.pop_front(); t = tagQ.pop_front();
      nCmp++;
      if (a !== e) begin
        nBad++;
        $display("FAIL %s: actual %0h expected %0h", t, a, e);
      end
    end
  endtask

  initial forever begin
    @(obsEv);
    drain();
  end

  task automatic push(input logic [15:0] act, input logic [15:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag); actQ.push_back(act);
    -> obsEv;
    #0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); busAddr = a; #1; v = busRdata;
  endtask

  task automatic chk(input logic [1:0] a, input logic [15:0] exp, input string tag);
    logic [15:0] v;
    rd(a, v);
    push(v, exp, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); tickStb = 1'b1; end
    @(negedge clk); tickStb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      drain();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    nCmp++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [15:0] v, prev;
    int bad;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R11 reset state
    chk(2'd0, 16'h0000, "R11 flags");
    chk(2'd2, 16'h0000, "R11 ctrl");
    chk(2'd3, 16'h0007, "R11 sel");
    chk(2'd1, 16'h0000, "R11 count");
    push({15'b0, irq}, 16'h0000, "R11 irq");

    // R3 disabled: ticks ignored
    ticks(50);
    chk(2'd1, 16'h0000, "R3 disabled");
    // R1 counting, bit 0 reads 0
    wr(2'd2, 16'h0001);
    ticks(100);
    chk(2'd1, 16'd200, "R1 count 100");
    // R3 hold after disable
    wr(2'd2, 16'h0000);
    ticks(40);
    chk(2'd1, 16'd200, "R3 hold");
    // R4 counter reset holds zero, then resumes
    wr(2'd2, 16'h0003);
    ticks(30);
    chk(2'd1, 16'h0000, "R4 held zero");
    wr(2'd2, 16'h0001);
    ticks(5);
    chk(2'd1, 16'd10, "R4 resume");

    // R7 sub-second, select 0 (every 256)
    wr(2'd3, 16'h0000);
    ticks(250);
    chk(2'd0, 16'h0000, "R7 before tap");
    ticks(1);
    chk(2'd1, 16'd512, "R1 count 256");
    chk(2'd0, 16'h0004, "R7 tap 256");
    push({15'b0, irq}, 16'h0001, "R9 irq set");
    wr(2'd0, 16'h0000);
    chk(2'd0, 16'h0004, "R6 write zero");
    wr(2'd0, 16'h0004);
    chk(2'd0, 16'h0000, "R6 write one");
    push({15'b0, irq}, 16'h0000, "R9 irq clear");

    // R7 select 1 (every 512), count at 256
    wr(2'd3, 16'h0001);
    ticks(511);
    chk(2'd0, 16'h0004, "R7 tap 512");
    wr(2'd0, 16'h0004);
    ticks(1);
    chk(2'd0, 16'h0000, "R7 no fire at 768");
    ticks(256);
    chk(2'd0, 16'h0004, "R7 tap 1024");
    wr(2'd0, 16'h0004);
    // R7 disabled
    wr(2'd3, 16'h0007);
    ticks(1024);
    chk(2'd0, 16'h0000, "R7 disabled");

    // R5 alarm
    @(negedge clk); alarmIn = 1'b1;
    @(negedge clk); alarmIn = 1'b0;
    repeat (2) @(negedge clk);
    chk(2'd0, 16'h0002, "R5 alarm flag");
    push({15'b0, irq}, 16'h0001, "R9 irq alarm");
    // R8 set wins
    @(negedge clk); alarmIn = 1'b1; busWr = 1'b1; busAddr = 2'd0; busWdata = 16'h0002;
    @(negedge clk); alarmIn = 1'b0; busWr = 1'b0;
    chk(2'd0, 16'h0002, "R8 set wins");
    wr(2'd0, 16'h0002);
    chk(2'd0, 16'h0000, "R6 alarm cleared");

    // R2 wrap
    wr(2'd2, 16'h0003);
    wr(2'd2, 16'h0001);
    ticks(32767);
    chk(2'd1, 16'hFFFE, "R2 count max");
    chk(2'd0, 16'h0000, "R2 no early wrap");
    push(16'(secSeen), 16'd0, "R2 no early pulse");
    ticks(1);
    chk(2'd1, 16'h0000, "R2 wrapped");
    chk(2'd0, 16'h0001, "R2 wrap flag");
    push(16'(secSeen), 16'd1, "R2 one pulse");
    wr(2'd0, 16'h0001);

    // R10 asynchronous source
    modeSync = 1'b0;
    wr(2'd2, 16'h0003);
    repeat (20) @(negedge clk);
    chk(2'd1, 16'h0000, "R4 async zero");
    wr(2'd2, 16'h0001);
    bad = 0;
    rd(2'd1, prev);
    for (int i = 0; i < 300; i++) begin
      rd(2'd1, v);
      if (15'(v[15:1] - prev[15:1]) > 15'd1) bad++;
      prev = v;
    end
    push(16'(bad), 16'd0, "R10 coherent steps");
    push({15'b0, (v[15:1] > 15'd50)}, 16'h0001, "R10 advanced");
    wr(2'd3, 16'h0000);
    repeat (800) @(negedge clk);
    chk(2'd0, 16'h0004, "R7 async tap");

    finishRun();
  end

endmodule